// File: doc/BRIEF.md
# Miss-Dependent Dispatch Gating Unit

This unit sits at the dispatch stage of a redundant multithreaded core. Leading and trailing copies of a program share one instruction queue. Each cycle, every hardware thread may offer the instruction at the head of its renamed stream. The unit chooses at most one thread to dispatch into the shared queue. It keeps one pending-miss flag for each physical register. A flag is raised when a load leaves the queue for execution and the cache-access predictor expects it to miss. The flag drops when that load's data comes back from the lower memory levels. A misprediction flush also drops the flags of the squashed destinations.

A leading thread whose head instruction reads a flagged register is passed over for that cycle, and selection moves on to the next thread. In this way, work that would only wait on a slow fill does not fill up the shared queue. The gating is per instruction and not per thread. An instruction that does not depend on a flagged register dispatches normally, even while its thread has misses outstanding. Trailing threads take their load values from the leading copy, so they are never gated. Threads with even index are leading and threads with odd index are trailing. Threads 2k and 2k+1 form one pair.

Top module: `mdg_gate`

## Requirements
- R1: After a synchronous active-high reset, all pending-miss flags are clear. The round-robin pointer is set so that thread 0 has first priority.
- R2: A load-issue event with `ld_miss`=1 sets the flag of `ld_preg`, and the flag is visible from the next cycle. An event with `ld_miss`=0 leaves the flags unchanged.
- R3: A fill event clears the flag of `fill_preg`, and the change is visible from the next cycle.
- R4: A set and a clear for the same register in the same cycle (from a fill or a flush) leave the flag set.
- R5: Every register whose bit is 1 in `flush_mask` has its flag cleared, and the change is visible from the next cycle.
- R6: A leading (even-index) thread is not eligible in a cycle in which any used source operand (`cand_use` bit 1) names a flagged register. A source with `cand_use`=0 has no effect on eligibility.
- R7: A trailing (odd-index) thread with a valid candidate is always eligible, whatever flags its sources name.
- R8: A leading thread with flags outstanding still dispatches a head instruction whose used sources are all unflagged.
- R9: Among eligible threads, the grant goes to the first one found when searching upward, with wrap-around, from the thread after the last thread granted. The pointer moves only on a grant.
- R10: When `q_free` is 0, `disp_en` is low and the round-robin pointer does not change.
- R11: When no thread is eligible, `disp_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_valid | input | 8 | Per-thread head instruction present |
| cand_src | input | 96 | Source physical registers. Thread t, operand s is at bits [(t*2+s)*6 +: 6] |
| cand_use | input | 16 | Source operand in use. Thread t, operand s is at bit t*2+s |
| ld_vld | input | 1 | A load leaves the queue for execution |
| ld_preg | input | 6 | Destination register of that load |
| ld_miss | input | 1 | Predictor expects that load to miss |
| fill_vld | input | 1 | Data for a missed load has returned |
| fill_preg | input | 6 | Destination register of the returned load |
| flush_mask | input | 64 | Destination registers squashed by a flush |
| q_free | input | 6 | Free entries in the shared queue (0..32) |
| disp_en | output | 1 | One thread dispatches this cycle |
| disp_tid | output | 3 | Thread selected; meaningful only when disp_en is 1 |

## Verification
The bench looks at the flags only through dispatch decisions. To probe one flag, it offers a leading thread whose single used source names that register. It then checks a set and a fill landing on the same register in the same cycle: a design that lets the clear win would let a dependent instruction dispatch too early. It checks a source that is flagged but marked unused: a design that ignores `cand_use` would stall that thread for no reason. It presents trailing threads that read flagged registers: gating them would starve the redundant copy. It holds `q_free` at 0 and then checks that the pointer did not move, since a design that advances the pointer without a grant breaks the round-robin order. A long mixed sweep over a small register window is then compared with an arithmetic model, cycle by cycle.

// File: rtl/mdg_pkg.sv
package mdg_pkg;
    localparam int NTHR_D   = 8;
    localparam int NSRC_D   = 2;
    localparam int NPREG_D  = 64;
    localparam int QDEPTH_D = 32;

    // Even-index threads are leading copies, odd-index are trailing copies.
    function automatic logic thread_is_leading(int t);
        return (t % 2) == 0;
    endfunction

    // Index of the thread k places after base, wrapping at n.
    function automatic int wrap_add(int base, int k, int n);
        int v;
        v = base + k;
        if (v >= n) v = v - n;
        return v;
    endfunction
endpackage

// File: rtl/mdg_miss_bits.sv
module mdg_miss_bits #(
    parameter int NPREG = 64,
    localparam int PW = $clog2(NPREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_vld,
    input  logic [PW-1:0]    set_preg,
    input  logic             clr_vld,
    input  logic [PW-1:0]    clr_preg,
    input  logic [NPREG-1:0] flush_mask,
    output logic [NPREG-1:0] pend
);
    for (genvar r = 0; r < NPREG; r++) begin : g_bit
        logic hit_set, hit_clr;
        assign hit_set = set_vld && (set_preg == PW'(r));
        assign hit_clr = (clr_vld && (clr_preg == PW'(r))) || flush_mask[r];
        always_ff @(posedge clk) begin
            if (rst)          pend[r] <= 1'b0;
            else if (hit_set) pend[r] <= 1'b1;   // set outranks clear
            else if (hit_clr) pend[r] <= 1'b0;
        end
    end

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
        set_vld |=> pend[$past(set_preg)]); // R4
    AST_FILL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (clr_vld && !(set_vld && set_preg == clr_preg)) |=> !pend[$past(clr_preg)]); // R3
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!set_vld && flush_mask != '0) |=> (pend & $past(flush_mask)) == '0); // R5
endmodule

// File: rtl/mdg_dep_check.sv
module mdg_dep_check #(
    parameter int NTHR  = 8,
    parameter int NSRC  = 2,
    parameter int NPREG = 64,
    localparam int PW = $clog2(NPREG)
) (
    input  logic [NPREG-1:0]        pend,
    input  logic [NTHR*NSRC*PW-1:0] cand_src,
    input  logic [NTHR*NSRC-1:0]    cand_use,
    output logic [NTHR-1:0]         dep_hit
);
    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        logic [NSRC-1:0] op_hit;
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            assign op_hit[s] = cand_use[t*NSRC+s] && pend[cand_src[(t*NSRC+s)*PW +: PW]];
        end
        assign dep_hit[t] = |op_hit;
    end
endmodule

// File: rtl/mdg_rr_pick.sv
module mdg_rr_pick #(
    parameter int NTHR = 8,
    localparam int TW = $clog2(NTHR)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NTHR-1:0] req,
    input  logic            allow,
    output logic            gnt_vld,
    output logic [TW-1:0]   gnt_id
);
    import mdg_pkg::*;
    logic [TW-1:0] last_q;
    logic          any_req;

    always_comb begin
        any_req = 1'b0;
        gnt_id  = '0;
        for (int k = NTHR; k >= 1; k--) begin
            int idx;
            idx = wrap_add(int'(last_q), k, NTHR);
            if (req[idx]) begin
                any_req = 1'b1;
                gnt_id  = TW'(idx);
            end
        end
    end

    assign gnt_vld = any_req && allow;

    always_ff @(posedge clk) begin
        if (rst)          last_q <= TW'(NTHR - 1);
        else if (gnt_vld) last_q <= gnt_id;
    end

    AST_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (rst)
        gnt_vld |-> req[gnt_id]); // R9
endmodule

// File: rtl/mdg_gate.sv
module mdg_gate #(
    parameter int NTHR   = mdg_pkg::NTHR_D,
    parameter int NSRC   = mdg_pkg::NSRC_D,
    parameter int NPREG  = mdg_pkg::NPREG_D,
    parameter int QDEPTH = mdg_pkg::QDEPTH_D,
    localparam int PW = $clog2(NPREG),
    localparam int TW = $clog2(NTHR),
    localparam int QW = $clog2(QDEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NTHR-1:0]         cand_valid,
    input  logic [NTHR*NSRC*PW-1:0] cand_src,
    input  logic [NTHR*NSRC-1:0]    cand_use,
    input  logic                    ld_vld,
    input  logic [PW-1:0]           ld_preg,
    input  logic                    ld_miss,
    input  logic                    fill_vld,
    input  logic [PW-1:0]           fill_preg,
    input  logic [NPREG-1:0]        flush_mask,
    input  logic [QW-1:0]           q_free,
    output logic                    disp_en,
    output logic [TW-1:0]           disp_tid
);
    import mdg_pkg::*;

    logic [NPREG-1:0] pend;
    logic [NTHR-1:0]  dep_hit, lead_mask, eligible;
    logic             room;

    for (genvar t = 0; t < NTHR; t++) begin : g_lead
        assign lead_mask[t] = thread_is_leading(t);
    end

    mdg_miss_bits #(.NPREG(NPREG)) u_bits (
        .clk(clk), .rst(rst),
        .set_vld(ld_vld && ld_miss), .set_preg(ld_preg),
        .clr_vld(fill_vld), .clr_preg(fill_preg),
        .flush_mask(flush_mask), .pend(pend)
    );

    mdg_dep_check #(.NTHR(NTHR), .NSRC(NSRC), .NPREG(NPREG)) u_dep (
        .pend(pend), .cand_src(cand_src), .cand_use(cand_use), .dep_hit(dep_hit)
    );

    assign eligible = cand_valid & ~(dep_hit & lead_mask);
    assign room     = (q_free != '0);

    mdg_rr_pick #(.NTHR(NTHR)) u_rr (
        .clk(clk), .rst(rst), .req(eligible), .allow(room),
        .gnt_vld(disp_en), .gnt_id(disp_tid)
    );

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (q_free == '0) |-> !disp_en); // R10
    AST_TRAIL_FREE: assert property (@(posedge clk) disable iff (rst)
        ((|(cand_valid & ~lead_mask)) && q_free != '0) |-> disp_en); // R7
    AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        (cand_valid == '0) |-> !disp_en); // R11
endmodule

// File: tb/sim_mdg_gate.sv
module sim_mdg_gate;
    localparam int T = 8, S = 2, NP = 64, PW = 6, TW = 3, QW = 6;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [T-1:0]    cand_valid = '0;
    logic [T*S*PW-1:0] cand_src = '0;
    logic [T*S-1:0]  cand_use = '0;
    logic            ld_vld = 1'b0, ld_miss = 1'b0, fill_vld = 1'b0;
    logic [PW-1:0]   ld_preg = '0, fill_preg = '0;
    logic [NP-1:0]   flush_mask = '0;
    logic [QW-1:0]   q_free = QW'(32);
    logic            disp_en;
    logic [TW-1:0]   disp_tid;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    bit m_pend [NP];
    int m_last;

    always #2 clk = ~clk;

    mdg_gate u0 (.*);

    task automatic put_src(int t, int s, int r, bit use_it);
        cand_src[(t*S+s)*PW +: PW] = PW'(r);
        cand_use[t*S+s] = use_it;
    endtask

    task automatic quiet();
        cand_valid = '0; cand_src = '0; cand_use = '0;
        ld_vld = 0; ld_miss = 0; fill_vld = 0; flush_mask = '0; q_free = QW'(32);
    endtask

    // Called just after a falling edge with inputs set; checks, updates model.
    task automatic cyc(string tag);
        bit elig [T];
        bit exp_en;
        int exp_tid;
        #1;
        for (int t = 0; t < T; t++) begin
            bit blk;
            blk = 0;
            for (int s = 0; s < S; s++)
                if (cand_use[t*S+s] && m_pend[cand_src[(t*S+s)*PW +: PW]]) blk = 1;
            elig[t] = cand_valid[t] && ((t % 2) == 1 || !blk);
        end
        exp_en = 0; exp_tid = 0;
        for (int k = 1; k <= T; k++) begin
            int idx;
            idx = (m_last + k) % T;
            if (!exp_en && elig[idx]) begin exp_en = 1; exp_tid = idx; end
        end
        if (q_free == 0) exp_en = 0;
        n_cmp++;
        if (disp_en !== exp_en) begin
            n_bad++;
            $display("FAIL %s: disp_en=%0b expected %0b", tag, disp_en, exp_en);
        end else if (exp_en && disp_tid !== TW'(exp_tid)) begin
            n_bad++;
            $display("FAIL %s: disp_tid=%0d expected %0d", tag, disp_tid, exp_tid);
        end
        for (int r = 0; r < NP; r++) begin
            if (flush_mask[r] || (fill_vld && fill_preg == PW'(r))) m_pend[r] = 0;
            if (ld_vld && ld_miss && ld_preg == PW'(r)) m_pend[r] = 1;
        end
        if (exp_en) m_last = exp_tid;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NP; r++) m_pend[r] = 0;
        m_last = T - 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: reset state, thread 0 first, flags clear
        quiet(); cand_valid = '1;
        for (int t = 0; t < T; t++) put_src(t, 0, t, 1);
        cyc("R1");
        // R2: miss-predicted load sets flag; hit-predicted does not
        quiet(); ld_vld = 1; ld_miss = 1; ld_preg = 5; cyc("R2");
        quiet(); ld_vld = 1; ld_miss = 0; ld_preg = 6; cyc("R2");
        quiet(); cand_valid[0] = 1; put_src(0, 1, 5, 1); cyc("R2");
        quiet(); cand_valid[0] = 1; put_src(0, 0, 6, 1); cyc("R2");
        // R6: unused flagged source ignored
        quiet(); cand_valid[2] = 1; put_src(2, 0, 5, 0); cyc("R6");
        quiet(); cand_valid = 8'b0000_0101; put_src(0, 0, 5, 1); put_src(2, 1, 5, 1); cyc("R6");
        // R7: trailing thread reading a flagged register
        quiet(); cand_valid = 8'b0000_0011; put_src(0, 0, 5, 1); put_src(1, 0, 5, 1); cyc("R7");
        // R8: same leading thread, independent instruction dispatches
        quiet(); cand_valid[4] = 1; put_src(4, 0, 5, 1); cyc("R8");
        quiet(); cand_valid[4] = 1; put_src(4, 0, 7, 1); put_src(4, 1, 8, 1); cyc("R8");
        // R4: set and fill on same register, set wins
        quiet(); ld_vld = 1; ld_miss = 1; ld_preg = 5; fill_vld = 1; fill_preg = 5; cyc("R4");
        quiet(); cand_valid[0] = 1; put_src(0, 0, 5, 1); cyc("R4");
        quiet(); ld_vld = 1; ld_miss = 1; ld_preg = 5; flush_mask[5] = 1; cyc("R4");
        quiet(); cand_valid[0] = 1; put_src(0, 0, 5, 1); cyc("R4");
        // R3: fill clears
        quiet(); fill_vld = 1; fill_preg = 5; cyc("R3");
        quiet(); cand_valid[0] = 1; put_src(0, 0, 5, 1); cyc("R3");
        // R5: flush clears multiple
        quiet(); ld_vld = 1; ld_miss = 1; ld_preg = 9; cyc("R5");
        quiet(); ld_vld = 1; ld_miss = 1; ld_preg = 10; cyc("R5");
        quiet(); flush_mask[9] = 1; flush_mask[10] = 1; cyc("R5");
        quiet(); cand_valid[6] = 1; put_src(6, 0, 9, 1); put_src(6, 1, 10, 1); cyc("R5");
        // R10: queue full blocks, pointer holds
        quiet(); cand_valid = '1; q_free = 0; cyc("R10");
        quiet(); cand_valid = '1; q_free = 1; cyc("R10");
        // R11: nothing eligible
        quiet(); cyc("R11");
        // R9: round-robin rotation with all requesting
        for (int i = 0; i < 2 * T; i++) begin
            quiet(); cand_valid = '1; cyc("R9");
        end
        // R9 + R6: mixed sweep over a small register window
        for (int i = 0; i < 4000; i++) begin
            quiet();
            cand_valid = T'($urandom);
            for (int t = 0; t < T; t++)
                for (int s = 0; s < S; s++) put_src(t, s, $urandom_range(0, 15), 1'($urandom));
            ld_vld = 1'($urandom); ld_miss = 1'($urandom); ld_preg = PW'($urandom_range(0, 15));
            fill_vld = ($urandom_range(0, 9) < 4); fill_preg = PW'($urandom_range(0, 15));
            if ($urandom_range(0, 19) == 0) flush_mask[$urandom_range(0, 15)] = 1;
            q_free = ($urandom_range(0, 9) == 0) ? QW'(0) : QW'($urandom_range(1, 32));
            cyc("R9");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule